// File: doc/BRIEF.md
# Serial Register-Access Slave with Burst Transfers

This block lets an external host reach a bank of 128 eight-bit control registers over a four-wire serial link. The host pulls an active-low select, toggles a serial clock and shifts bits in on a data input. The block answers on a data output. Every transfer opens with a command byte. Its top bit gives the direction and its low seven bits give the register address. One or more data bytes follow the command byte.

If the host keeps select low past the first data byte, the transfer moves on to the next register. This gives burst reads and writes without a new command byte. Device logic beside the bank has its own port, with which it reads any register and writes any register.

The serial pins are brought into the system clock through a synchroniser. Edge detection, shifting and every register update happen on the system clock, so the serial clock must be several times slower than the system clock.

Top module: `spi_regbank_slave`

## Requirements
- R1: A frame is sent most significant bit first. It is one command byte followed by data bytes. Command bit 7 is the direction and command bits 6..0 are the register address. Input bits are taken on rising serial-clock edges, and every eighth rising edge closes a byte.
- R2: A direction bit of 1 makes the frame a write. The addressed register takes the data byte once its eighth bit has been received.
- R3: A direction bit of 0 makes the frame a read. The register contents appear on the output, most significant bit first. Each bit is driven on a falling edge, and the first bit is driven on the falling edge of the eighth command pulse. Data on the input line during a read changes no register.
- R4: While select stays low, each further data byte goes to the next address: it is written there in a write frame, or read from there in a read frame.
- R5: The address advances from 127 to 0.
- R6: Raising select part-way through a byte drops that partial byte, writes nothing, and makes the next frame begin with a fresh command byte.
- R7: The output is high while select is high, during the command byte, and throughout a write frame. While select stays low, the output changes only on falling edges. With no further clock pulses it keeps its level until select rises. The falling edge that closes a read byte already drives the first bit of the next register.
- R8: The side port returns, without a clock, the contents of the register it addresses. It writes a register on one system clock when its write strobe is high.
- R9: After reset every register reads 0 and the output is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| spi_sel_n | input | 1 | Active-low frame select from the host |
| spi_sck | input | 1 | Serial clock from the host, idles low |
| spi_mosi | input | 1 | Serial data from the host |
| spi_miso | output | 1 | Serial data to the host, idles high |
| dev_addr | input | 7 | Side-port register address |
| dev_we | input | 1 | Side-port write strobe |
| dev_wdata | input | 8 | Side-port write data |
| dev_rdata | output | 8 | Side-port read data for dev_addr |

## Verification
The bench fills all 128 registers with values derived from their addresses, then reads every one back over the serial link. A wrong bit order, a wrong address decode or an output that moves one edge late would corrupt these bytes. Burst frames start at 120 and 124 so that the address crosses 127. A design without wrap-around, or one that increments twice per byte, would write to or read from the wrong registers.

Further tests hold the input line high through a read and cut frames short mid-byte. A design that wrote during reads, or kept stale bit counts, would change a register or misframe the next command. The output is also sampled after the clock stops and after select rises, to catch an output that drifts or fails to return high.

// File: rtl/spi_rb_pkg.sv
// Package: shared types for the serial register-access slave.
// Assumes nothing beyond the parameters passed to each module.
package spi_rb_pkg;
    // Frame phase: command byte first, then any number of data bytes
    typedef enum logic {
        PH_CMD  = 1'b0,
        PH_DATA = 1'b1
    } phase_t;
endpackage

// File: rtl/spi_rb_sync.sv
// Module: spi_rb_sync
// Multi-stage synchroniser for a vector of asynchronous inputs.
// Assumes STAGES >= 2 and that every bit of din changes slowly compared
// with clk. RST_VAL is the idle level of each bit.
module spi_rb_sync #(
    parameter int          WIDTH   = 3,
    parameter int          STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    logic [STAGES-1:0][WIDTH-1:0] chain;

    // Shift the inputs through the flop chain
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain <= {STAGES{RST_VAL}};
        end else begin
            chain <= {chain[STAGES-2:0], din};
        end
    end

    assign dout = chain[STAGES-1];
endmodule

// File: rtl/spi_rb_bank.sv
// Module: spi_rb_bank
// Register bank of 2**ADDR_W words with two asynchronous read ports
// and two write ports. The serial write port takes priority over the
// side write port when both strobe the same word in one cycle.
// Assumes synchronous active-low reset, which clears every word.
module spi_rb_bank #(
    parameter int ADDR_W = 7,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              spi_we,
    input  logic [ADDR_W-1:0] spi_waddr,
    input  logic [DATA_W-1:0] spi_wdata,
    input  logic [ADDR_W-1:0] spi_raddr,
    output logic [DATA_W-1:0] spi_rdata,
    input  logic              dev_we,
    input  logic [ADDR_W-1:0] dev_addr,
    input  logic [DATA_W-1:0] dev_wdata,
    output logic [DATA_W-1:0] dev_rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_word
        // Update one word, serial port first, side port second
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                mem[g] <= '0;
            end else if (spi_we && (spi_waddr == ADDR_W'(g))) begin
                mem[g] <= spi_wdata;
            end else if (dev_we && (dev_addr == ADDR_W'(g))) begin
                mem[g] <= dev_wdata;
            end
        end
    end

    assign spi_rdata = mem[spi_raddr];
    assign dev_rdata = mem[dev_addr];
endmodule

// File: rtl/spi_rb_engine.sv
// Module: spi_rb_engine
// Frame engine. It detects serial clock edges from synchronised
// pins, shifts bits in on rising edges and shifts bits out on falling
// edges. It decodes the command byte and steps the address per data
// byte. Assumes ADDR_W < DATA_W (the command byte holds direction +
// address) and a serial clock well below clk.
module spi_rb_engine
    import spi_rb_pkg::*;
#(
    parameter int ADDR_W = 7,
    parameter int DATA_W = 8,
    parameter int BIT_W  = $clog2(DATA_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel_n_s,
    input  logic              sck_s,
    input  logic              mosi_s,
    output logic              miso,
    output logic              spi_we,
    output logic [ADDR_W-1:0] spi_waddr,
    output logic [DATA_W-1:0] spi_wdata,
    output logic [ADDR_W-1:0] spi_raddr,
    input  logic [DATA_W-1:0] spi_rdata,
    output logic              sel_act,
    output logic              sck_rise,
    output logic              sck_fall,
    output logic              byte_done,
    output logic              in_data,
    output logic [ADDR_W-1:0] addr,
    output logic [BIT_W-1:0]  bit_cnt
);
    localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(DATA_W - 1);

    logic              sck_q;
    logic [DATA_W-2:0] shreg;
    logic [DATA_W-1:0] new_byte;
    logic [DATA_W-1:0] osr;
    logic              is_wr;
    phase_t            phase;
    logic              cmd_done;
    logic              data_done;
    logic              load_osr;

    // Edge and framing decode
    always_comb begin
        sel_act   = ~sel_n_s;
        sck_rise  = sel_act & sck_s & ~sck_q;
        sck_fall  = sel_act & ~sck_s & sck_q;
        byte_done = sck_rise & (bit_cnt == LAST_BIT);
        new_byte  = {shreg, mosi_s};
        in_data   = (phase == PH_DATA);
        cmd_done  = byte_done & ~in_data;
        data_done = byte_done & in_data;
        spi_we    = data_done & is_wr;
        spi_waddr = addr;
        spi_wdata = new_byte;
        load_osr  = (cmd_done & ~new_byte[DATA_W-1]) | (data_done & ~is_wr);
        spi_raddr = cmd_done ? new_byte[ADDR_W-1:0] : addr + 1'b1;
    end

    // Previous serial clock level for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) sck_q <= 1'b0;
        else        sck_q <= sck_s;
    end

    // Bit position within the current byte
    always_ff @(posedge clk) begin
        if (!rst_n || !sel_act) begin
            bit_cnt <= '0;
        end else if (sck_rise) begin
            bit_cnt <= byte_done ? '0 : bit_cnt + 1'b1;
        end
    end

    // Input shifter, filled on rising edges
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg <= '0;
        end else if (sck_rise) begin
            shreg <= new_byte[DATA_W-2:0];
        end
    end

    // Phase, direction and address tracking
    always_ff @(posedge clk) begin
        if (!rst_n || !sel_act) begin
            phase <= PH_CMD;
            is_wr <= 1'b0;
            if (!rst_n) addr <= '0;
        end else if (cmd_done) begin
            phase <= PH_DATA;
            is_wr <= new_byte[DATA_W-1];
            addr  <= new_byte[ADDR_W-1:0];
        end else if (data_done) begin
            addr  <= addr + 1'b1;
        end
    end

    // Output shifter and pin, loaded at byte ends, shifted on falls
    always_ff @(posedge clk) begin
        if (!rst_n || !sel_act) begin
            osr  <= '1;
            miso <= 1'b1;
        end else if (load_osr) begin
            osr  <= spi_rdata;
        end else if (sck_fall && in_data && !is_wr) begin
            miso <= osr[DATA_W-1];
            osr  <= {osr[DATA_W-2:0], 1'b1};
        end
    end
endmodule

// File: rtl/spi_regbank_slave.sv
// Module: spi_regbank_slave (top)
// Serial register-access slave: synchroniser, frame engine and
// register bank with a side port for device logic.
// Assumes the serial clock idles low and runs at most about clk/8.
module spi_regbank_slave #(
    parameter int ADDR_W      = 7,
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              spi_sel_n,
    input  logic              spi_sck,
    input  logic              spi_mosi,
    output logic              spi_miso,
    input  logic [ADDR_W-1:0] dev_addr,
    input  logic              dev_we,
    input  logic [DATA_W-1:0] dev_wdata,
    output logic [DATA_W-1:0] dev_rdata
);
    localparam int BIT_W = $clog2(DATA_W);

    logic [2:0]        pins_s;
    logic              spi_we;
    logic [ADDR_W-1:0] spi_waddr;
    logic [DATA_W-1:0] spi_wdata;
    logic [ADDR_W-1:0] spi_raddr;
    logic [DATA_W-1:0] spi_rdata;
    logic              sel_act;
    logic              sck_rise;
    logic              sck_fall;
    logic              byte_done;
    logic              in_data;
    logic [ADDR_W-1:0] addr;
    logic [BIT_W-1:0]  bit_cnt;

    spi_rb_sync #(
        .WIDTH   (3),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (3'b100)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   ({spi_sel_n, spi_sck, spi_mosi}),
        .dout  (pins_s)
    );

    spi_rb_engine #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .BIT_W  (BIT_W)
    ) u_engine (
        .clk       (clk),
        .rst_n     (rst_n),
        .sel_n_s   (pins_s[2]),
        .sck_s     (pins_s[1]),
        .mosi_s    (pins_s[0]),
        .miso      (spi_miso),
        .spi_we    (spi_we),
        .spi_waddr (spi_waddr),
        .spi_wdata (spi_wdata),
        .spi_raddr (spi_raddr),
        .spi_rdata (spi_rdata),
        .sel_act   (sel_act),
        .sck_rise  (sck_rise),
        .sck_fall  (sck_fall),
        .byte_done (byte_done),
        .in_data   (in_data),
        .addr      (addr),
        .bit_cnt   (bit_cnt)
    );

    spi_rb_bank #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .spi_we    (spi_we),
        .spi_waddr (spi_waddr),
        .spi_wdata (spi_wdata),
        .spi_raddr (spi_raddr),
        .spi_rdata (spi_rdata),
        .dev_we    (dev_we),
        .dev_addr  (dev_addr),
        .dev_wdata (dev_wdata),
        .dev_rdata (dev_rdata)
    );
endmodule

// File: rtl/spi_rb_checker.sv
// Module: spi_rb_checker
// Temporal checks on the frame engine and output pin, bound into the top.
// Assumes the signal meanings of spi_rb_engine.
module spi_rb_checker #(
    parameter int ADDR_W = 7,
    parameter int BIT_W  = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              sel_act,
    input logic              sck_rise,
    input logic              sck_fall,
    input logic              byte_done,
    input logic              in_data,
    input logic              spi_we,
    input logic [ADDR_W-1:0] addr,
    input logic [BIT_W-1:0]  bit_cnt,
    input logic              miso
);
    AST_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        !sel_act |=> miso); // R7
    AST_MISO_ON_FALL_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        sel_act && !sck_fall |=> $stable(miso)); // R7
    AST_CMD_PHASE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        !in_data |-> miso); // R7
    AST_WRITE_AT_BYTE_END: assert property (@(posedge clk) disable iff (!rst_n)
        spi_we |-> (sck_rise && in_data && byte_done)); // R2
    AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        byte_done && in_data |=> addr == ADDR_W'($past(addr) + 1'b1)); // R4 R5
    AST_BITCNT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        !sel_act |=> bit_cnt == '0); // R6
    AST_BITCNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        sck_rise && !byte_done |=> bit_cnt == BIT_W'($past(bit_cnt) + 1'b1)); // R1
    AST_NO_EDGE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !sel_act |-> !sck_rise && !sck_fall); // R6
endmodule

bind spi_regbank_slave spi_rb_checker #(
    .ADDR_W (ADDR_W),
    .BIT_W  (BIT_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .sel_act   (sel_act),
    .sck_rise  (sck_rise),
    .sck_fall  (sck_fall),
    .byte_done (byte_done),
    .in_data   (in_data),
    .spi_we    (spi_we),
    .addr      (addr),
    .bit_cnt   (bit_cnt),
    .miso      (spi_miso)
);

// File: tb/spi_regbank_slave_test.sv
// Bench for spi_regbank_slave: sweeps every register over the serial
// link and exercises bursts, wrap-around, aborted frames and pin idling.
module spi_regbank_slave_test;
    localparam int HP = 8;   // serial half period in system clocks

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       spi_sel_n = 1'b1;
    logic       spi_sck = 1'b0;
    logic       spi_mosi = 1'b0;
    logic       spi_miso;
    logic [6:0] dev_addr = '0;
    logic       dev_we = 1'b0;
    logic [7:0] dev_wdata = '0;
    logic [7:0] dev_rdata;

    int checks = 0;
    int failures = 0;
    logic [7:0] model [128];

    always #2 clk = ~clk;

    spi_regbank_slave uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .spi_sel_n (spi_sel_n),
        .spi_sck   (spi_sck),
        .spi_mosi  (spi_mosi),
        .spi_miso  (spi_miso),
        .dev_addr  (dev_addr),
        .dev_we    (dev_we),
        .dev_wdata (dev_wdata),
        .dev_rdata (dev_rdata)
    );

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] fill_val(input int a);
        return 8'((a * 37 + 5) & 255);
    endfunction

    // Shift n bits of tx out, returning what was seen on the output
    task automatic spi_bits(input logic [7:0] tx, input int n, output logic [7:0] rx);
        rx = '1;
        for (int i = 7; i > 7 - n; i--) begin
            spi_mosi = tx[i];
            wait_clk(HP);
            rx[i] = spi_miso;
            spi_sck = 1'b1;
            wait_clk(HP);
            spi_sck = 1'b0;
        end
    endtask

    task automatic sel_low();
        spi_sel_n = 1'b0;
        wait_clk(HP);
    endtask

    task automatic sel_high();
        wait_clk(HP);
        spi_sel_n = 1'b1;
        wait_clk(2 * HP);
    endtask

    task automatic side_write(input int a, input logic [7:0] d);
        dev_addr  = 7'(a);
        dev_wdata = d;
        dev_we    = 1'b1;
        wait_clk(1);
        dev_we    = 1'b0;
        model[a]  = d;
    endtask

    task automatic side_read(input int a, output logic [7:0] d);
        dev_addr = 7'(a);
        wait_clk(1);
        d = dev_rdata;
    endtask

    initial begin
        logic [7:0] rx;
        logic [7:0] rd;
        for (int a = 0; a < 128; a++) model[a] = '0;
        wait_clk(4);
        rst_n = 1'b1;
        wait_clk(2);

        // R9: reset state
        chk("R9 miso idle", spi_miso, 1);
        side_read(0, rd);
        chk("R9 reg0 cleared", rd, 0);
        side_read(127, rd);
        chk("R9 reg127 cleared", rd, 0);

        // R8: preload every register through the side port and read back
        for (int a = 0; a < 128; a++) side_write(a, fill_val(a));
        side_read(77, rd);
        chk("R8 side readback", rd, fill_val(77));

        // R1 R3: read every register over the serial link
        for (int a = 0; a < 128; a++) begin
            sel_low();
            spi_bits(8'(a), 8, rx);
            if (a == 0) chk("R7 miso high in command", rx, 8'hFF);
            spi_bits(8'h00, 8, rx);
            chk($sformatf("R3 read addr %0d", a), rx, model[a]);
            sel_high();
        end

        // R2: single write frame
        sel_low();
        spi_bits(8'h80 | 8'd127, 8, rx);
        spi_bits(8'hC3, 8, rx);
        chk("R7 miso high in write frame", rx, 8'hFF);
        sel_high();
        model[127] = 8'hC3;
        side_read(127, rd);
        chk("R2 single write", rd, 8'hC3);

        // R4 R5: burst write from 120 crossing 127
        sel_low();
        spi_bits(8'h80 | 8'd120, 8, rx);
        for (int i = 0; i < 16; i++) spi_bits(8'((i * 11) ^ 8'h5A), 8, rx);
        sel_high();
        for (int i = 0; i < 16; i++) begin
            model[(120 + i) % 128] = 8'((i * 11) ^ 8'h5A);
            side_read((120 + i) % 128, rd);
            chk($sformatf("R4 R5 burst write idx %0d", i), rd, model[(120 + i) % 128]);
        end
        side_read(8, rd);
        chk("R4 burst stops at last byte", rd, fill_val(8));
        side_read(119, rd);
        chk("R4 burst leaves 119", rd, fill_val(119));

        // R4 R5 R7: burst read from 124 crossing 127, then hold
        sel_low();
        spi_bits(8'd124, 8, rx);
        for (int i = 0; i < 8; i++) begin
            spi_bits(8'h00, 8, rx);
            chk($sformatf("R4 R5 burst read idx %0d", i), rx, model[(124 + i) % 128]);
        end
        wait_clk(20);
        chk("R7 hold after clocks stop", spi_miso, model[4][7]);
        wait_clk(20);
        chk("R7 hold still", spi_miso, model[4][7]);
        spi_sel_n = 1'b1;
        wait_clk(2 * HP);
        chk("R7 idle after select rises", spi_miso, 1);

        // R3: input data ignored during a read
        sel_low();
        spi_bits(8'd50, 8, rx);
        spi_bits(8'hFF, 8, rx);
        chk("R3 read with mosi high", rx, model[50]);
        sel_high();
        side_read(50, rd);
        chk("R3 read leaves reg50", rd, model[50]);
        side_read(51, rd);
        chk("R3 read leaves reg51", rd, model[51]);

        // R6: abort part-way through a data byte
        sel_low();
        spi_bits(8'h80 | 8'd10, 8, rx);
        spi_bits(8'h00, 5, rx);
        sel_high();
        side_read(10, rd);
        chk("R6 partial data byte dropped", rd, model[10]);

        // R6: abort inside the command byte, then a full write frames afresh
        sel_low();
        spi_bits(8'hFF, 3, rx);
        sel_high();
        sel_low();
        spi_bits(8'h80 | 8'd33, 8, rx);
        spi_bits(8'h96, 8, rx);
        sel_high();
        model[33] = 8'h96;
        side_read(33, rd);
        chk("R6 fresh frame after abort", rd, 8'h96);
        side_read(127, rd);
        chk("R6 aborted command wrote nothing", rd, model[127]);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    // Watchdog: a hung run counts as a failure
    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule